// File: doc/BRIEF.md
# Address Trace Capture Analyzer

This block is an embedded analyzer that watches a processor address bus and keeps a history of the addresses seen inside one selected address block. It writes those addresses into a circular store of 1024 entries. Capture stops a programmable number of states after a trigger, so the store holds history from both before and after the trigger. The trigger fires on a chosen count of hits on a trigger address, or when software forces it.

Software drives the analyzer with single command words. These start or stop recording, open or close a collect gate, and force the trigger. A five-bit status word shows progress. A collect gate that is independent of recording lets software leave uninteresting stretches out of the store, for example everything outside an interrupt handler, while trigger counting goes on. When capture ends, the block latches the position of the oldest entry. A simple indexed read port then returns the history in time order, with the oldest entry first.

Top module: `trace_capture_analyzer`

## Requirements
- R1: After reset, `status` is all zero and `rd_data` is zero.
- R2: A command takes effect at the clock edge on which `cmd_we` is high. The command bits are: bit 10 starts recording, bit 11 stops recording, bit 12 opens the collect gate and bit 13 closes it. Starting recording also clears the triggered, done and wrapped flags and the trigger hit count. When start and stop of the same function appear in one word, the stop wins.
- R3: An entry is written only on a cycle that meets all four conditions: `bus_valid` is high, `bus_addr[23:17]` equals `cfg_block`, recording is on and the collect gate is open. The value written is `bus_addr[16:0]`.
- R4: While recording and not yet triggered, each valid in-block address whose low 17 bits equal `cfg_trig_addr` counts as one hit, whether or not the collect gate is open. The trigger fires on hit number `cfg_trig_m1`+1, so 1 to 1024 hits are possible. Hits outside the block, or with recording off, are not counted.
- R5: Command bit 14 forces the trigger when recording is on and the trigger has not yet fired. It has no effect when recording is off. A state stored in the trigger cycle is the trigger state and is not counted as a post-trigger state.
- R6: After the trigger, exactly `cfg_post` further states are stored. On the last of them, recording turns off and the done flag sets. If `cfg_post` is 0, this happens in the trigger cycle itself. Once done, addresses on the bus leave the store unchanged.
- R7: `rd_data` presents entry `rd_idx` one clock after `rd_idx` is applied. Entries are counted from the oldest state. When capture ends, the oldest position is latched: it is 0 if the store never wrapped, and otherwise the position following the last write. The index wraps modulo 1024.
- R8: The wrapped flag sets on the 1024th store after a start. Later stores overwrite the oldest entries, so the most recent 1024 states are kept.
- R9: The `status` bits are: bit 0 done, bit 1 wrapped, bit 2 recording, bit 3 collect open, bit 4 triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Address strobe for `bus_addr` |
| bus_addr | input | 24 | Observed processor address |
| cfg_block | input | 7 | Selected block (upper address bits) |
| cfg_trig_addr | input | 17 | Trigger address offset within the block |
| cfg_trig_m1 | input | 10 | Trigger hit count minus one |
| cfg_post | input | 10 | Number of states stored after the trigger |
| cmd_we | input | 1 | Command strobe |
| cmd_word | input | 16 | Command word, bits 14..10 used |
| rd_idx | input | 10 | Read index from the oldest entry |
| rd_data | output | 17 | Entry at `rd_idx`, one cycle later |
| status | output | 5 | Done, wrapped, recording, collect, triggered |

## Verification
Two functions can land in the same cycle: a forced trigger and the storing of an in-block address. The bench issues the force command on the same edge that an address is presented, after the store has wrapped. It then checks that exactly `cfg_post` more states follow before done sets, and that the coincident address sits four entries from the newest. A second coincidence also gets coverage: with `cfg_post` at zero, the final counted hit both triggers and ends the capture. The bench judges this by the stored trigger state being the last entry.

// File: rtl/trace_capture_pkg.sv
// Package: command bit positions and status bit positions shared by the
// analyzer, its checker and its bench.
package trace_capture_pkg;
    localparam int CMD_W       = 16;
    localparam int CMD_REC_ON  = 10;
    localparam int CMD_REC_OFF = 11;
    localparam int CMD_COL_ON  = 12;
    localparam int CMD_COL_OFF = 13;
    localparam int CMD_FORCE   = 14;

    localparam int ST_W    = 5;
    localparam int ST_DONE = 0;
    localparam int ST_WRAP = 1;
    localparam int ST_REC  = 2;
    localparam int ST_COL  = 3;
    localparam int ST_TRIG = 4;
endpackage

// File: rtl/trc_addr_match.sv
// Splits the observed address into block and offset, flags a valid in-block
// address and flags a trigger-offset match. Purely combinational.
// Assumes the block field occupies the bits above the offset.
module trc_addr_match #(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 17,
    localparam int BLK_W = ADDR_W - OFF_W
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BLK_W-1:0]  cfg_block,
    input  logic [OFF_W-1:0]  cfg_trig_addr,
    output logic              in_blk,
    output logic              trig_hit,
    output logic [OFF_W-1:0]  offset
);
    // Decode block membership and trigger equality
    always_comb begin
        offset   = bus_addr[OFF_W-1:0];
        in_blk   = bus_valid && (bus_addr[ADDR_W-1:OFF_W] == cfg_block);
        trig_hit = in_blk && (offset == cfg_trig_addr);
    end
endmodule

// File: rtl/trc_capture_ctrl.sv
// Capture control: record and collect flags, trigger hit counting, the
// post-trigger countdown and the done flag. Emits a restart pulse and a
// finish pulse for the buffer. Assumes store is already gated by record and
// collect.
module trc_capture_ctrl
    import trace_capture_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             trig_hit,
    input  logic             store,
    input  logic [IDX_W-1:0] cfg_trig_m1,
    input  logic [IDX_W-1:0] cfg_post,
    output logic             record,
    output logic             collect,
    output logic             triggered,
    output logic             done,
    output logic             restart,
    output logic             finish
);
    logic             rec_on, rec_off, col_on, col_off, force_trig, trig_evt;
    logic [IDX_W-1:0] hits;
    logic [IDX_W-1:0] post_left;

    // Decode commands and the trigger and finish events of this cycle
    always_comb begin
        rec_on     = cmd_we && cmd_word[CMD_REC_ON];
        rec_off    = cmd_we && cmd_word[CMD_REC_OFF];
        col_on     = cmd_we && cmd_word[CMD_COL_ON];
        col_off    = cmd_we && cmd_word[CMD_COL_OFF];
        force_trig = cmd_we && cmd_word[CMD_FORCE];
        restart    = rec_on && !rec_off;
        trig_evt   = record && !triggered && !rec_on && !rec_off &&
                     (force_trig || (trig_hit && hits == cfg_trig_m1));
        finish     = !rec_on && !rec_off && record &&
                     ((trig_evt && cfg_post == '0) ||
                      (triggered && store && post_left == IDX_W'(1)));
    end

    // Collect gate: close wins over open
    always_ff @(posedge clk) begin
        if (!rst_n)       collect <= 1'b0;
        else if (col_off) collect <= 1'b0;
        else if (col_on)  collect <= 1'b1;
    end

    // Record, trigger counting and post-trigger countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            record    <= 1'b0;
            triggered <= 1'b0;
            done      <= 1'b0;
            hits      <= '0;
            post_left <= '0;
        end else if (rec_off) begin
            record <= 1'b0;
        end else if (rec_on) begin
            record    <= 1'b1;
            triggered <= 1'b0;
            done      <= 1'b0;
            hits      <= '0;
        end else if (record) begin
            if (!triggered) begin
                if (trig_evt) begin
                    triggered <= 1'b1;
                    post_left <= cfg_post;
                end else if (trig_hit) begin
                    hits <= hits + IDX_W'(1);
                end
            end else if (store) begin
                post_left <= post_left - IDX_W'(1);
            end
            if (finish) begin
                record <= 1'b0;
                done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/trc_buffer.sv
// Circular store of DEPTH entries with a write pointer, a wrapped flag and a
// latched oldest position used to read back in time order. DEPTH must be a
// power of two. Read data is registered (one cycle latency).
module trc_buffer #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 17,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              restart,
    input  logic              finish,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              wrapped
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  wr_ptr, oldest, wr_next;
    logic              wrap_next;

    // Pointer and wrap state after this cycle's store
    always_comb begin
        wr_next   = store ? wr_ptr + IDX_W'(1) : wr_ptr;
        wrap_next = wrapped || (store && wr_ptr == IDX_W'(DEPTH - 1));
    end

    // Storage array write
    always_ff @(posedge clk) begin
        if (store) mem[wr_ptr] <= wr_data;
    end

    // Write pointer, wrapped flag and oldest-entry latch
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
            oldest  <= '0;
        end else begin
            wr_ptr  <= wr_next;
            wrapped <= wrap_next;
            if (finish) oldest <= wrap_next ? wr_next : '0;
        end
    end

    // Registered readback relative to the oldest entry
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[oldest + rd_idx];
    end
endmodule

// File: rtl/trace_capture_analyzer.sv
// Top of the address trace analyzer: address decode, capture control and the
// circular store. Configuration inputs are assumed steady while recording.
module trace_capture_analyzer
    import trace_capture_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 17,
    parameter int DEPTH  = 1024,
    localparam int BLK_W = ADDR_W - OFF_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BLK_W-1:0]  cfg_block,
    input  logic [OFF_W-1:0]  cfg_trig_addr,
    input  logic [IDX_W-1:0]  cfg_trig_m1,
    input  logic [IDX_W-1:0]  cfg_post,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [OFF_W-1:0]  rd_data,
    output logic [ST_W-1:0]   status
);
    logic             in_blk, trig_hit, store;
    logic             record, collect, triggered, done, restart, finish, wrapped;
    logic [OFF_W-1:0] offset;

    trc_addr_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
        .bus_valid(bus_valid), .bus_addr(bus_addr), .cfg_block(cfg_block),
        .cfg_trig_addr(cfg_trig_addr), .in_blk(in_blk), .trig_hit(trig_hit),
        .offset(offset)
    );

    // Store qualifier: valid in-block address, recording, collect open
    always_comb store = in_blk && record && collect;

    trc_capture_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .trig_hit(trig_hit), .store(store), .cfg_trig_m1(cfg_trig_m1),
        .cfg_post(cfg_post), .record(record), .collect(collect),
        .triggered(triggered), .done(done), .restart(restart), .finish(finish)
    );

    trc_buffer #(.DEPTH(DEPTH), .DATA_W(OFF_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .store(store), .wr_data(offset),
        .restart(restart), .finish(finish), .rd_idx(rd_idx),
        .rd_data(rd_data), .wrapped(wrapped)
    );

    // Status word assembly
    always_comb begin
        status          = '0;
        status[ST_DONE] = done;
        status[ST_WRAP] = wrapped;
        status[ST_REC]  = record;
        status[ST_COL]  = collect;
        status[ST_TRIG] = triggered;
    end
endmodule

// File: rtl/trace_capture_analyzer_chk.sv
// Checker for the analyzer's command and status behaviour, bound to the top.
module trace_capture_analyzer_chk
    import trace_capture_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [CMD_W-1:0] cmd_word,
    input logic [ST_W-1:0]  status
);
    logic start_only;
    always_comb start_only = cmd_we && cmd_word[CMD_REC_ON] && !cmd_word[CMD_REC_OFF];

    a_r2_stop_record: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_word[CMD_REC_OFF] |=> !status[ST_REC]);

    a_r2_start_record: assert property (@(posedge clk) disable iff (!rst_n)
        start_only |=> status[ST_REC] && !status[ST_TRIG] && !status[ST_DONE] && !status[ST_WRAP]);

    a_r2_close_collect: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_word[CMD_COL_OFF] |=> !status[ST_COL]);

    a_r5_force_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_word[CMD_FORCE] && !cmd_word[CMD_REC_ON] && !cmd_word[CMD_REC_OFF]
        && status[ST_REC] |=> status[ST_TRIG]);

    a_r6_done_stops_record: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_DONE]) |-> !status[ST_REC] && status[ST_TRIG]);

    a_r8_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_WRAP] && !start_only |=> status[ST_WRAP]);

    a_r9_done_after_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_DONE] |-> status[ST_TRIG]);
endmodule

bind trace_capture_analyzer trace_capture_analyzer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word), .status(status)
);

// File: tb/trace_capture_analyzer_bench.sv
// Bench: command table walk, then directed capture, trigger and wrap tests.
module trace_capture_analyzer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [6:0]  cfg_block = 7'h03;
    logic [16:0] cfg_trig_addr = 17'h00100;
    logic [9:0]  cfg_trig_m1 = '0;
    logic [9:0]  cfg_post = 10'd5;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [9:0]  rd_idx = '0;
    logic [16:0] rd_data;
    logic [4:0]  status;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state derived from the requirements
    logic [16:0] mm [1024];
    int   m_wp = 0, m_start = 0, m_hits = 0, m_pleft = 0;
    logic m_wrap = 0, m_rec = 0, m_col = 0, m_trig = 0, m_done = 0;

    always #10 clk = ~clk;

    trace_capture_analyzer u_trace_capture_analyzer (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .cfg_block(cfg_block), .cfg_trig_addr(cfg_trig_addr),
        .cfg_trig_m1(cfg_trig_m1), .cfg_post(cfg_post), .cmd_we(cmd_we),
        .cmd_word(cmd_word), .rd_idx(rd_idx), .rd_data(rd_data), .status(status)
    );

    // {command word, expected status after it}, cfg_post = 5
    localparam logic [20:0] TBL [10] = '{
        {16'h1400, 5'b01100},  // R2 both starts
        {16'h2000, 5'b00100},  // R2 close collect
        {16'h0C00, 5'b00000},  // R2 record stop wins
        {16'h1000, 5'b01000},  // R2 open collect
        {16'h3000, 5'b00000},  // R2 collect close wins
        {16'h1400, 5'b01100},  // R2 start again
        {16'h4000, 5'b11100},  // R5 force while recording
        {16'h0400, 5'b01100},  // R2 restart clears trigger
        {16'h2800, 5'b00000},  // R2 stop both
        {16'h4000, 5'b00000}   // R5 force ignored when idle
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [23:0] a, input logic we, input logic [15:0] c);
        logic blk, st, mt, sr, pr, sc, pc, ft, te, fin;
        logic [16:0] off;
        @(negedge clk);
        bus_valid = v; bus_addr = a; cmd_we = we; cmd_word = c;
        blk = v && (a[23:17] == cfg_block);
        off = a[16:0];
        st  = blk && m_rec && m_col;
        mt  = blk && (off == cfg_trig_addr);
        sr = we && c[10]; pr = we && c[11]; sc = we && c[12];
        pc = we && c[13]; ft = we && c[14];
        te  = m_rec && !m_trig && !sr && !pr && (ft || (mt && m_hits == int'(cfg_trig_m1)));
        fin = !sr && !pr && m_rec && ((te && cfg_post == 0) || (m_trig && st && m_pleft == 1));
        if (st) mm[m_wp] = off;
        if (sr && !pr) begin
            m_wp = 0; m_wrap = 0; m_start = 0;
        end else begin
            if (st) begin
                if (m_wp == 1023) m_wrap = 1;
                m_wp = (m_wp + 1) % 1024;
            end
            if (fin) m_start = m_wrap ? m_wp : 0;
        end
        if (sc) m_col = 1;
        if (pc) m_col = 0;
        if (pr) m_rec = 0;
        else if (sr) begin
            m_rec = 1; m_trig = 0; m_done = 0; m_hits = 0;
        end else if (m_rec) begin
            if (!m_trig) begin
                if (te) begin m_trig = 1; m_pleft = int'(cfg_post); end
                else if (mt) m_hits++;
            end else if (st) m_pleft--;
            if (fin) begin m_rec = 0; m_done = 1; end
        end
        @(posedge clk);
        #2;
        bus_valid = 1'b0; cmd_we = 1'b0; cmd_word = '0;
    endtask

    task automatic rd_chk(input int idx, input logic [16:0] exp, input string tag);
        @(negedge clk);
        rd_idx = idx[9:0];
        @(posedge clk);
        #2;
        chk(32'(rd_data), 32'(exp), tag);
    endtask

    function automatic logic [16:0] mdl_rd(input int idx);
        return mm[(m_start + idx) % 1024];
    endfunction

    function automatic logic [4:0] mdl_st();
        return {m_trig, m_col, m_rec, m_wrap, m_done};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mm[i] = '0;
        repeat (3) @(posedge clk);
        #2;
        chk(32'(status), 0, "R1 status after reset");
        chk(32'(rd_data), 0, "R1 rd_data after reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: command decoding and status mapping (R2, R5, R9)
        for (int k = 0; k < 10; k++) begin
            cyc(1'b0, '0, 1'b1, TBL[k][20:5]);
            chk(32'(status), 32'(TBL[k][4:0]), $sformatf("R2/R9 table step %0d", k));
        end

        // Capture, counted trigger, post window (R3 R4 R6 R7)
        cfg_trig_m1 = 10'd2; cfg_post = 10'd4;
        cyc(1'b0, '0, 1'b1, 16'h1400);
        for (int i = 0; i < 6; i++) cyc(1'b1, {7'h03, 17'(17'h10 + i)}, 1'b0, '0);
        cyc(1'b1, {7'h05, 17'h00020}, 1'b0, '0);
        cyc(1'b0, {7'h03, 17'h00030}, 1'b0, '0);
        cyc(1'b1, {7'h03, 17'h00100}, 1'b0, '0);
        cyc(1'b1, {7'h05, 17'h00100}, 1'b0, '0);
        cyc(1'b1, {7'h03, 17'h00100}, 1'b0, '0);
        chk(32'(status), 32'(5'b01100), "R4 not triggered after two hits");
        cyc(1'b1, {7'h03, 17'h00100}, 1'b0, '0);
        chk(32'(status), 32'(5'b11100), "R4 triggered on third hit");
        for (int i = 0; i < 3; i++) cyc(1'b1, {7'h03, 17'(17'h40 + i)}, 1'b0, '0);
        chk(32'(status), 32'(5'b11100), "R6 still recording before last post state");
        cyc(1'b1, {7'h03, 17'h00043}, 1'b0, '0);
        chk(32'(status), 32'(5'b11001), "R6 done after post states");
        cyc(1'b1, {7'h03, 17'h00050}, 1'b0, '0);
        chk(32'(status), 32'(5'b11001), "R6 status unchanged after done");
        rd_chk(0, 17'h00010, "R3 oldest entry");
        rd_chk(6, 17'h00100, "R3 first hit stored, out-of-block skipped");
        rd_chk(12, 17'h00043, "R7 newest entry");
        for (int i = 0; i < 13; i++) rd_chk(i, mdl_rd(i), $sformatf("R7 entry %0d", i));

        // Hits counted with collect closed, post count zero (R4 R6)
        cfg_trig_m1 = 10'd1; cfg_post = 10'd0;
        cyc(1'b0, '0, 1'b1, 16'h2400);
        cyc(1'b1, {7'h03, 17'h00100}, 1'b0, '0);
        cyc(1'b0, '0, 1'b1, 16'h1000);
        cyc(1'b1, {7'h03, 17'h00060}, 1'b0, '0);
        cyc(1'b1, {7'h03, 17'h00100}, 1'b0, '0);
        chk(32'(status), 32'(5'b11001), "R6 zero post count ends at trigger");
        rd_chk(0, 17'h00060, "R3 hit with collect closed not stored");
        rd_chk(1, 17'h00100, "R6 trigger state is last entry");

        // Wrap, forced trigger coinciding with a store (R5 R7 R8)
        cfg_trig_addr = 17'h1FFFF; cfg_trig_m1 = 10'd0; cfg_post = 10'd3;
        cyc(1'b0, '0, 1'b1, 16'h0400);
        for (int i = 0; i < 1030; i++) cyc(1'b1, {7'h03, 17'(17'h200 + i)}, 1'b0, '0);
        chk(32'(status), 32'(5'b01110), "R8 wrapped flag set");
        cyc(1'b1, {7'h03, 17'h07000}, 1'b1, 16'h4000);
        chk(32'(status), 32'(5'b11110), "R5 forced trigger with store");
        for (int i = 1; i < 4; i++) cyc(1'b1, {7'h03, 17'(17'h7000 + i)}, 1'b0, '0);
        chk(32'(status), 32'(5'b11011), "R6 done after three post states");
        chk(32'(status), 32'(mdl_st()), "R9 status matches model");
        rd_chk(0, 17'h0020A, "R8 oldest after wrap");
        rd_chk(1020, 17'h07000, "R5 trigger state four from newest");
        rd_chk(1023, 17'h07003, "R7 newest after wrap");
        cyc(1'b1, {7'h03, 17'h00009}, 1'b0, '0);
        rd_chk(0, 17'h0020A, "R6 store ignored after done");

        // Restart clears wrap; readback from position zero (R2 R7)
        cyc(1'b0, '0, 1'b1, 16'h0400);
        chk(32'(status), 32'(5'b01100), "R2 restart clears wrapped");
        rd_chk(0, mdl_rd(0), "R7 readback from zero after restart");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule